// File: doc/BRIEF.md
# Secondary processor reset and bus-takeover control

This block gives the main processor a two-bit control and status word over a secondary processor. One bit holds the secondary processor in reset or lets it run. The other bit asks to take over the secondary processor's bus. The block drives the active-low reset and halt lines of that processor. It watches the processor's address strobe and its stop-instruction state, and from them it reports whether the bus is free for the main side.

The takeover uses only the halt line. There is no request/grant exchange with the processor. The bus is reported as available only when all three of these hold:
- halt is asserted, either by the request bit or by reset;
- the address strobe has shown an idle bus;
- the processor is not parked in a stop-instruction state.

The same availability flag steers a shared program memory. While the flag is 1, the memory belongs to the main side. While it is 0, the memory belongs to the secondary side. A main-side access to memory the main side does not own is refused: a write is dropped, and a read returns a fixed marker word.

The main-side memory port carries no back-pressure. Every request held valid for one cycle is taken in that cycle. Its read data comes back exactly one cycle later with `m_rvalid`, and the requester must accept it.

Top module: `subcpu_ctrl`

## Requirements
- R1: After power-on reset, `sub_reset_n` and `sub_halt_n` are 0, and `reg_rdata[0]` (the run bit) reads 0.
- R2: Writing `reg_wdata[0]`=0 drives `sub_reset_n` and `sub_halt_n` to 0 from the next cycle. `reg_rdata[0]` always reads back the level of `sub_reset_n`.
- R3: After the run bit is written from 0 to 1, `sub_reset_n` and `sub_halt_n` stay 0 for MIN_RST_CYC (default 10) more cycles after the write cycle, and then rise if no request is pending. Reset is therefore held for at least MIN_RST_CYC cycles.
- R4: Writing `reg_wdata`=2'b11 while the processor runs drives `sub_halt_n` to 0 from the next cycle and leaves `sub_reset_n` at 1.
- R5: `reg_rdata[1]` (bus available) becomes 1 one cycle after the first clock edge at which halt is asserted and `sub_as_n` is 1. While `sub_as_n` stays 0, it stays 0.
- R6: While the run bit is 0, `reg_rdata[1]` reaches 1 even when the request bit is 0.
- R7: While `sub_stopped` is 1, `reg_rdata[1]` reads 0 in the same cycle, whatever was written.
- R8: One cycle after halt is released, `reg_rdata[1]` reads 0.
- R9: While `reg_rdata[1]` is 1, a main write reaches the memory. A main read returns the memory word at `m_rdata` one cycle later, with `m_rvalid` set.
- R10: While `reg_rdata[1]` is 0, a main write leaves the memory unchanged. A main read returns 16'hC3A5 one cycle later, with `m_rvalid` set.
- R11: While `reg_rdata[1]` is 0, secondary accesses reach the memory and read data appears on `s_rdata` one cycle later. While it is 1, secondary accesses are blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 2 | Bit 0 run, bit 1 bus request |
| reg_rdata | output | 2 | Bit 0 reset line level, bit 1 bus available |
| sub_reset_n | output | 1 | Reset to the secondary processor, active low |
| sub_halt_n | output | 1 | Halt to the secondary processor, active low |
| sub_as_n | input | 1 | Secondary address strobe, active low |
| sub_stopped | input | 1 | Secondary processor parked by a stop instruction |
| m_valid | input | 1 | Main memory request |
| m_we | input | 1 | Main request is a write |
| m_addr | input | ADDR_W | Main address |
| m_wdata | input | DATA_W | Main write data |
| m_rvalid | output | 1 | Main read data valid |
| m_rdata | output | DATA_W | Main read data or refusal marker |
| s_valid | input | 1 | Secondary memory request |
| s_we | input | 1 | Secondary request is a write |
| s_addr | input | ADDR_W | Secondary address |
| s_wdata | input | DATA_W | Secondary write data |
| s_rdata | output | DATA_W | Secondary read data |
| mem_en | output | 1 | Memory enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle latency |

## Verification
The assertions assume that `sub_as_n` and `sub_stopped` are clean levels that are already synchronised to `clk`. They also assume the attached memory answers reads after exactly one cycle. The stimulus keeps to these assumptions: it changes every input only on the falling edge, and it models the memory as a one-cycle array. The stop indication is held for runs of cycles rather than toggled every cycle. Main and secondary requests are issued together on purpose, so that the blocking paths are exercised under contention.

// File: rtl/subctl_pkg.sv
package subctl_pkg;
  localparam int CTL_RUN = 0;
  localparam int CTL_REQ = 1;

  typedef struct packed {
    logic req;
    logic run;
  } ctl_bits_t;
endpackage

// File: rtl/subctl_regs.sv
module subctl_regs
  import subctl_pkg::*;
#(
  parameter int MIN_RST_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic       sub_reset_n,
  output logic       sub_halt_n,
  output logic       halt_active
);
  localparam int CNT_W = $clog2(MIN_RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MIN_RST_CYC);

  ctl_bits_t        ctl_q;
  logic [CNT_W-1:0] hold_q;
  logic             reset_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      hold_q <= CNT_LOAD;
    end else begin
      if (wr_en) ctl_q <= ctl_bits_t'(wr_data);
      if (!ctl_q.run) hold_q <= CNT_LOAD;
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end
  end

  assign reset_active = !ctl_q.run || (hold_q != '0);
  assign sub_reset_n  = !reset_active;
  assign sub_halt_n   = !(reset_active || ctl_q.req);
  assign halt_active  = !sub_halt_n;

  // checker state: cycles the reset line has been low, saturating
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run_q <= '0;
    else if (sub_reset_n) low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  // R2
  run_clear_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CTL_RUN]) |=> (!sub_reset_n && !sub_halt_n));

  // R3
  reset_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_reset_n) |-> (low_run_q >= (CNT_W+1)'(MIN_RST_CYC)));

  // R4
  request_halts_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 2'b11 && sub_reset_n) |=> (sub_reset_n && !sub_halt_n));
endmodule

// File: rtl/subctl_grant.sv
module subctl_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_active,
  input  logic sub_as_n,
  input  logic sub_stopped,
  output logic bus_avail
);
  logic gr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gr_q <= 1'b0;
    else        gr_q <= halt_active && (gr_q || sub_as_n);
  end

  assign bus_avail = gr_q && !sub_stopped;

  // R5
  grant_waits_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gr_q) |-> $past(sub_as_n));

  // R8
  release_drops_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_active |=> !bus_avail);
endmodule

// File: rtl/subctl_memsel.sv
module subctl_memsel #(
  parameter int                ADDR_W        = 8,
  parameter int                DATA_W        = 16,
  parameter logic [DATA_W-1:0] CONFLICT_WORD = DATA_W'('hC3A5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_own,
  input  logic              m_valid,
  input  logic              m_we,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_rvalid,
  output logic [DATA_W-1:0] m_rdata,
  input  logic              s_valid,
  input  logic              s_we,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic main_go, sub_go, own_q;

  assign main_go   = m_valid && main_own;
  assign sub_go    = s_valid && !main_own;
  assign mem_en    = main_go || sub_go;
  assign mem_we    = main_go ? m_we : (sub_go && s_we);
  assign mem_addr  = main_own ? m_addr : s_addr;
  assign mem_wdata = main_own ? m_wdata : s_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rvalid <= 1'b0;
      own_q    <= 1'b0;
    end else begin
      m_rvalid <= m_valid && !m_we;
      own_q    <= main_own;
    end
  end

  assign m_rdata = own_q ? mem_rdata : CONFLICT_WORD;
  assign s_rdata = mem_rdata;

  // R9
  main_reaches_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && main_own) |-> (mem_en && mem_addr == m_addr));

  // R10
  refused_main_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !main_own && !s_valid) |-> !mem_en);

  // R10
  refused_read_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_we && !main_own) |=> (m_rvalid && m_rdata == CONFLICT_WORD));

  // R11
  sub_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && main_own && !m_valid) |-> !mem_en);
endmodule

// File: rtl/subcpu_ctrl.sv
module subcpu_ctrl
  import subctl_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter int                DATA_W        = 16,
  parameter int                MIN_RST_CYC   = 10,
  parameter logic [DATA_W-1:0] CONFLICT_WORD = DATA_W'('hC3A5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_wdata,
  output logic [1:0]        reg_rdata,
  output logic              sub_reset_n,
  output logic              sub_halt_n,
  input  logic              sub_as_n,
  input  logic              sub_stopped,
  input  logic              m_valid,
  input  logic              m_we,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_rvalid,
  output logic [DATA_W-1:0] m_rdata,
  input  logic              s_valid,
  input  logic              s_we,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  output logic [DATA_W-1:0] s_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic halt_active, bus_avail;

  subctl_regs #(.MIN_RST_CYC(MIN_RST_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_data(reg_wdata),
    .sub_reset_n(sub_reset_n), .sub_halt_n(sub_halt_n),
    .halt_active(halt_active)
  );

  subctl_grant u_grant (
    .clk(clk), .rst_n(rst_n), .halt_active(halt_active),
    .sub_as_n(sub_as_n), .sub_stopped(sub_stopped), .bus_avail(bus_avail)
  );

  subctl_memsel #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONFLICT_WORD(CONFLICT_WORD)
  ) u_memsel (
    .clk(clk), .rst_n(rst_n), .main_own(bus_avail),
    .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .s_valid(s_valid), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign reg_rdata[CTL_RUN] = sub_reset_n;
  assign reg_rdata[CTL_REQ] = bus_avail;

  // R7
  stop_hides_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stopped |-> !reg_rdata[CTL_REQ]);

  // R2
  reset_implies_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_reset_n |-> !sub_halt_n);
endmodule

// File: tb/test_subcpu_ctrl.sv
module test_subcpu_ctrl;
  localparam int MINC = 10;
  localparam logic [15:0] MARK = 16'hC3A5;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [1:0] reg_wdata = 0; logic [1:0] reg_rdata;
  logic sub_reset_n, sub_halt_n;
  logic sub_as_n = 1, sub_stopped = 0;
  logic m_valid = 0, m_we = 0; logic [7:0] m_addr = 0; logic [15:0] m_wdata = 0;
  logic m_rvalid; logic [15:0] m_rdata;
  logic s_valid = 0, s_we = 0; logic [7:0] s_addr = 0; logic [15:0] s_wdata = 0;
  logic [15:0] s_rdata;
  logic mem_en, mem_we; logic [7:0] mem_addr; logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  subcpu_ctrl i_subcpu_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sub_reset_n(sub_reset_n), .sub_halt_n(sub_halt_n),
    .sub_as_n(sub_as_n), .sub_stopped(sub_stopped),
    .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .s_valid(s_valid), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory array attached to the block, one cycle read latency
  logic [15:0] bmem [256];
  logic [15:0] emem [256];
  initial for (int i = 0; i < 256; i++) begin
    bmem[i] = 16'(i * 3 + 1);
    emem[i] = 16'(i * 3 + 1);
  end
  always @(posedge clk) if (mem_en) begin
    if (mem_we) bmem[mem_addr] <= mem_wdata;
    else        mem_rdata <= bmem[mem_addr];
  end

  // expected-state model, written from the requirements
  bit e_run, e_req, e_gr, e_rv, e_srv;
  int e_cnt;
  logic [15:0] e_rd, e_srd;

  function automatic bit exp_reset_n(); return e_run && e_cnt == 0; endfunction
  function automatic bit exp_halt_n(); return exp_reset_n() && !e_req; endfunction
  function automatic bit exp_avail(); return e_gr && !sub_stopped; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_run = 0; e_req = 0; e_gr = 0; e_cnt = MINC; e_rv = 0; e_srv = 0;
    end else begin
      bit own, want;
      own  = exp_avail();
      want = !exp_halt_n();
      e_rv = m_valid && !m_we;
      if (e_rv) e_rd = own ? emem[m_addr] : MARK;
      e_srv = !own && s_valid && !s_we;
      if (e_srv) e_srd = emem[s_addr];
      if (own && m_valid && m_we) emem[m_addr] = m_wdata;
      if (!own && s_valid && s_we) emem[s_addr] = s_wdata;
      e_gr = want && (e_gr || sub_as_n);
      if (!e_run) e_cnt = MINC; else if (e_cnt != 0) e_cnt--;
      if (reg_wr) begin e_run = reg_wdata[0]; e_req = reg_wdata[1]; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2 run readback", 32'(reg_rdata[0]), 32'(exp_reset_n()));
    check("R3 reset line", 32'(sub_reset_n), 32'(exp_reset_n()));
    check("R4 halt line", 32'(sub_halt_n), 32'(exp_halt_n()));
    check("R5 avail", 32'(reg_rdata[1]), 32'(exp_avail()));
    check("R9 rvalid", 32'(m_rvalid), 32'(e_rv));
    if (e_rv) check(e_rd == MARK ? "R10 main read" : "R9 main read", 32'(m_rdata), 32'(e_rd));
    if (e_srv) check("R11 sub read", 32'(s_rdata), 32'(e_srd));
  endtask

  // one clock: edge, then compare on the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    reg_wr = 0; m_valid = 0; s_valid = 0;
  endtask

  task automatic wreg(input logic [1:0] v);
    reg_wr = 1; reg_wdata = v; tick();
  endtask

  task automatic mreq(input bit we, input logic [7:0] a, input logic [15:0] d);
    m_valid = 1; m_we = we; m_addr = a; m_wdata = d; tick();
  endtask

  task automatic sreq(input bit we, input logic [7:0] a, input logic [15:0] d);
    s_valid = 1; s_we = we; s_addr = a; s_wdata = d; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 reset_n", 32'(sub_reset_n), 0);
    check("R1 halt_n", 32'(sub_halt_n), 0);
    check("R1 run bit", 32'(reg_rdata[0]), 0);
    tick();
    // R6 avail while held in reset with no request
    check("R6 avail in reset", 32'(reg_rdata[1]), 1);
    // R3 stretch after releasing reset
    wreg(2'b01);
    for (int k = 1; k <= MINC - 1; k++) tick();
    check("R3 still held", 32'(sub_reset_n), 0);
    tick();
    check("R3 released", 32'(sub_reset_n), 1);
    check("R3 halt released", 32'(sub_halt_n), 1);
    tick();
    check("R8 avail dropped", 32'(reg_rdata[1]), 0);
    // R4 / R5 request while bus busy
    sub_as_n = 0;
    wreg(2'b11);
    check("R4 halt", 32'(sub_halt_n), 0);
    check("R4 reset untouched", 32'(sub_reset_n), 1);
    tick(); tick();
    check("R5 waits for strobe", 32'(reg_rdata[1]), 0);
    sub_as_n = 1;
    tick();
    check("R5 granted", 32'(reg_rdata[1]), 1);
    // R9 owned access
    mreq(1, 8'd5, 16'h1234);
    mreq(0, 8'd5, 0);
    tick();
    check("R9 read back", 32'(m_rdata), 32'h1234);
    // R7 stop state hides availability at once
    sub_stopped = 1; #1;
    check("R7 stopped", 32'(reg_rdata[1]), 0);
    mreq(0, 8'd5, 0);
    mreq(1, 8'd5, 16'hBEEF);
    check("R10 marker", 32'(m_rdata), 32'(MARK));
    sub_stopped = 0;
    mreq(0, 8'd5, 0);
    tick();
    check("R10 write dropped", 32'(m_rdata), 32'h1234);
    // R8 release request, then secondary side owns memory
    wreg(2'b01);
    check("R8 halt off", 32'(sub_halt_n), 1);
    tick();
    check("R8 avail off", 32'(reg_rdata[1]), 0);
    sreq(1, 8'd6, 16'h5A5A);
    sreq(0, 8'd6, 0);
    tick();
    check("R11 sub data", 32'(s_rdata), 32'h5A5A);
    // R2 reset through register write
    wreg(2'b00);
    check("R2 reset", 32'(sub_reset_n), 0);
    check("R2 halt", 32'(sub_halt_n), 0);
    check("R2 readback", 32'(reg_rdata[0]), 0);
    tick();
    check("R6 avail via reset", 32'(reg_rdata[1]), 1);
    sub_stopped = 1; #1;
    check("R7 stopped in reset", 32'(reg_rdata[1]), 0);
    sub_stopped = 0;
    // random phase, checked against the model every cycle
    for (int n = 0; n < 3000; n++) begin
      reg_wr    = ($urandom % 12) == 0;
      reg_wdata = 2'($urandom);
      sub_as_n  = ($urandom % 4) != 0;
      if (($urandom % 20) == 0) sub_stopped = ~sub_stopped;
      m_valid = $urandom % 2; m_we = $urandom % 2;
      m_addr = 8'($urandom % 16); m_wdata = 16'($urandom);
      s_valid = ($urandom % 3) == 0; s_we = $urandom % 2;
      s_addr = 8'($urandom % 16); s_wdata = 16'($urandom);
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule